// File: doc/BRIEF.md
# Network Controller Command/Status Interrupt Registers

This block is the host-facing control window of a network controller. It keeps a 16-bit status word whose upper byte holds sticky event flags and whose lower byte shows the live states of the command unit and the receive unit. It also keeps a command word through which the host hands a command-unit code and a receive-unit code to those units, an interrupt control byte, and a 32-bit general pointer. A single level-sensitive interrupt line goes to the host.

The host reaches the registers through a simple 32-bit write port with byte enables and a combinational read port. Word 0 packs four byte lanes: lane 0 is the status low byte, lane 1 the status high byte (the acknowledge byte), lane 2 the command byte and lane 3 the interrupt control byte. Word 1 is the pointer. A written command code stays visible and stays offered to its unit until that unit pulses its accept input. The host therefore polls the command byte until it reads zero. Event flags are cleared by writing ones into the acknowledge byte.

The internal engines are outside the block. They appear only as one-cycle event pulses, state inputs and accept pulses.

Top module: `nic_cmd_status_regs`

## Requirements
- R1: After a synchronous active-low reset, all event flags, the interrupt mask, both pending command codes and the pointer are zero, and `irq` is low.
- R2: A one-cycle event pulse sets its flag, and the flag reads back in word 0 from the next cycle on. The bit positions are: command done 15, frame received 14, command unit left active 13, receiver left ready 12, management cycle done 11, software interrupt 10, flow-control pause 8. Bit 9 always reads 0.
- R3: A word-0 write with byte enable 1 clears each flag whose bit in `host_wdata[15:8]` is 1, within the acknowledge mask 0xFD00. Flags written with 0 are unchanged.
- R4: When an event pulse and a clear of the same flag fall in the same cycle, the flag stays set.
- R5: A word-0 write with byte enable 2 loads the command-unit code from `host_wdata[23:20]` and the receive-unit code from `host_wdata[18:16]`. They read back at `host_rdata[23:20]` and `host_rdata[18:16]`, bit 19 reads 0, and a zero field leaves that unit's pending code unchanged.
- R6: A pending code stays on `cu_cmd_code`/`ru_cmd_code` with its valid output high until the matching accept pulse. It then reads zero from the next cycle. The two units are accepted independently, and an accept with nothing pending has no effect.
- R7: A word-0 write with byte enable 3 sets the interrupt mask from `host_wdata[24]`, which reads back at `host_rdata[24]`. In the same write, `host_wdata[25]` = 1 raises the software-interrupt flag (bit 10). Bit 25 always reads back 0.
- R8: `irq` is high exactly when the mask is 0 and at least one event flag is set.
- R9: `host_rdata[7:6]` shows `cu_state`, `host_rdata[5:2]` shows `ru_state` (idle 0, suspended 1, no resources 2, ready 4, plus 8 when out of buffer descriptors), and `host_rdata[1:0]` read 0.
- R10: Word-1 writes update the pointer byte by byte under the byte enables. Word 1 reads the pointer back, and `ptr_out` drives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_word | input | 1 | Word select: 0 control/status word, 1 pointer |
| host_be | input | 4 | Byte enables for the write |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the selected word |
| ev_cmd_done | input | 1 | Command completed pulse |
| ev_frame_rx | input | 1 | Frame received pulse |
| ev_cu_idle | input | 1 | Command unit left active state pulse |
| ev_rx_stall | input | 1 | Receiver left ready state pulse |
| ev_mgmt_done | input | 1 | Management read/write cycle finished pulse |
| ev_pause | input | 1 | Flow-control pause pulse |
| cu_state | input | 2 | Current command unit state |
| ru_state | input | 4 | Current receive unit state |
| cu_cmd_code | output | 4 | Pending command-unit code |
| cu_cmd_valid | output | 1 | Command-unit code is pending |
| cu_accept | input | 1 | Command unit takes the pending code |
| ru_cmd_code | output | 3 | Pending receive-unit code |
| ru_cmd_valid | output | 1 | Receive-unit code is pending |
| ru_accept | input | 1 | Receive unit takes the pending code |
| ptr_out | output | 32 | General pointer value |
| irq | output | 1 | Level interrupt to the host |

## Verification
On every cycle the assertions check the following. An event pulse leaves its flag set, even against a simultaneous clear. A clear with no competing event removes the flag. A pending command holds until its accept, and the accept empties the slot. A set mask keeps the interrupt low, while an unmasked event raises it. Several things need the bench's scenarios and its reference model, because they only show over sequences of writes: the exact read-back layout of every byte lane, the rule that a zero field leaves the other unit's pending code alone, the independence of the two accepts when both codes arrive in one write, and the byte-granular pointer updates.

// File: rtl/csr_pkg.sv
// Package: shared constants for the command/status register block.
// Assumes a 32-bit host data path and the byte-lane layout of word 0.
package csr_pkg;
    localparam int HOST_W   = 32;
    localparam int PTR_W    = 32;
    localparam int FLAG_W   = 8;
    localparam int CU_W     = 4;
    localparam int RU_W     = 3;
    localparam int CUST_W   = 2;
    localparam int RUST_W   = 4;
    // Acknowledge mask for the status high byte (status bits 15:8 = 0xFD)
    localparam logic [FLAG_W-1:0] ACK_HI = 8'hFD;
    // Flag indices inside the status high byte
    localparam int F_CMD_DONE = 7;
    localparam int F_FRAME_RX = 6;
    localparam int F_CU_IDLE  = 5;
    localparam int F_RX_STALL = 4;
    localparam int F_MGMT     = 3;
    localparam int F_SWI      = 2;
    localparam int F_PAUSE    = 0;
    // Byte lanes of word 0
    localparam int LANE_ACK   = 1;
    localparam int LANE_CMD   = 2;
    localparam int LANE_ICTL  = 3;
endpackage

// File: rtl/csr_evt_flags.sv
// Sticky event flags with write-one-to-clear.
// What it does: holds one flag per implemented bit; a set request beats a
// clear request in the same cycle. Assumes set/clr are already restricted
// to the acknowledge mask; unimplemented bits read as zero.
module csr_evt_flags #(
    parameter int W = 8,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_impl
            // One flag: set has priority over clear
            always_ff @(posedge clk) begin
                if (!rst_n)          flags_q[i] <= 1'b0;
                else if (set_vec[i]) flags_q[i] <= 1'b1;
                else if (clr_vec[i]) flags_q[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign flags_q[i] = 1'b0 & (set_vec[i] | clr_vec[i]);
        end
    end
endmodule

// File: rtl/csr_cmd_slot.sv
// One pending-command slot for an internal unit.
// What it does: captures a nonzero code on load, offers it with a valid
// flag, and empties on accept. Assumes a load wins over a same-cycle accept.
module csr_cmd_slot #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] code_in,
    input  logic         accept,
    output logic [W-1:0] code_q,
    output logic         valid
);
    // Hold the code until the unit takes it
    always_ff @(posedge clk) begin
        if (!rst_n)                          code_q <= '0;
        else if (load && (code_in != '0))    code_q <= code_in;
        else if (accept)                     code_q <= '0;
    end

    // A slot is offered whenever it holds a nonzero code
    always_comb valid = (code_q != '0);
endmodule

// File: rtl/csr_ptr_reg.sv
// Byte-writable general pointer register.
// What it does: updates each byte whose enable is set on a write.
// Assumes BYTES*8 bits of write data.
module csr_ptr_reg #(
    parameter int BYTES = 4,
    localparam int W = BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BYTES-1:0] be,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     q
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        // One byte lane of the pointer
        always_ff @(posedge clk) begin
            if (!rst_n)             q[b*8 +: 8] <= 8'h00;
            else if (wr && be[b])   q[b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end
endmodule

// File: rtl/nic_cmd_status_regs.sv
// Command/status interrupt register block (top).
// What it does: decodes host writes into flag acknowledges, command
// hand-off, interrupt control and pointer updates; assembles read data;
// drives the level interrupt. Assumes single-cycle event and accept pulses
// and a synchronous active-low reset.
module nic_cmd_status_regs
    import csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_word,
    input  logic [3:0]        host_be,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              ev_cmd_done,
    input  logic              ev_frame_rx,
    input  logic              ev_cu_idle,
    input  logic              ev_rx_stall,
    input  logic              ev_mgmt_done,
    input  logic              ev_pause,
    input  logic [CUST_W-1:0] cu_state,
    input  logic [RUST_W-1:0] ru_state,
    output logic [CU_W-1:0]   cu_cmd_code,
    output logic              cu_cmd_valid,
    input  logic              cu_accept,
    output logic [RU_W-1:0]   ru_cmd_code,
    output logic              ru_cmd_valid,
    input  logic              ru_accept,
    output logic [PTR_W-1:0]  ptr_out,
    output logic              irq
);
    localparam int PTR_BYTES = PTR_W / 8;

    logic              wr_ctl, wr_ptr;
    logic [FLAG_W-1:0] set_vec, clr_vec, flags_hi;
    logic              swi_set, mask_q, cmd_load;

    // Split host writes by word
    always_comb begin
        wr_ctl = host_wr && !host_word;
        wr_ptr = host_wr &&  host_word;
    end

    // Software-interrupt request from the interrupt control byte
    always_comb swi_set = wr_ctl && host_be[LANE_ICTL] && host_wdata[25];

    // Collect event requests into status-high-byte order
    always_comb begin
        set_vec             = '0;
        set_vec[F_CMD_DONE] = ev_cmd_done;
        set_vec[F_FRAME_RX] = ev_frame_rx;
        set_vec[F_CU_IDLE]  = ev_cu_idle;
        set_vec[F_RX_STALL] = ev_rx_stall;
        set_vec[F_MGMT]     = ev_mgmt_done;
        set_vec[F_SWI]      = swi_set;
        set_vec[F_PAUSE]    = ev_pause;
        set_vec             = set_vec & ACK_HI;
    end

    // Write-one-to-clear requests from the acknowledge byte
    always_comb clr_vec = (wr_ctl && host_be[LANE_ACK]) ? (host_wdata[15:8] & ACK_HI) : '0;

    csr_evt_flags #(.W(FLAG_W), .IMPL(ACK_HI)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags_hi)
    );

    // Command byte write strobe
    always_comb cmd_load = wr_ctl && host_be[LANE_CMD];

    csr_cmd_slot #(.W(CU_W)) u_cu_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_load),
        .code_in (host_wdata[23:20]),
        .accept  (cu_accept),
        .code_q  (cu_cmd_code),
        .valid   (cu_cmd_valid)
    );

    csr_cmd_slot #(.W(RU_W)) u_ru_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_load),
        .code_in (host_wdata[18:16]),
        .accept  (ru_accept),
        .code_q  (ru_cmd_code),
        .valid   (ru_cmd_valid)
    );

    // Interrupt mask bit from the interrupt control byte
    always_ff @(posedge clk) begin
        if (!rst_n)                              mask_q <= 1'b0;
        else if (wr_ctl && host_be[LANE_ICTL])   mask_q <= host_wdata[24];
    end

    csr_ptr_reg #(.BYTES(PTR_BYTES)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ptr),
        .be    (host_be[PTR_BYTES-1:0]),
        .wdata (host_wdata[PTR_W-1:0]),
        .q     (ptr_out)
    );

    // Read data of the selected word
    always_comb begin
        if (host_word)
            host_rdata = ptr_out;
        else
            host_rdata = {6'b0, 1'b0, mask_q,
                          cu_cmd_code, 1'b0, ru_cmd_code,
                          flags_hi,
                          cu_state, ru_state, 2'b00};
    end

    // Level interrupt: any flag while unmasked
    always_comb irq = !mask_q && (flags_hi != '0);
endmodule

// File: rtl/nic_cmd_status_regs_chk.sv
// Checker: temporal properties of the command/status register block.
// Assumes it is bound into nic_cmd_status_regs and sees its internal
// flag byte and mask bit.
module nic_cmd_status_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_word,
    input logic [3:0] host_be,
    input logic [31:0] host_wdata,
    input logic       ev_cmd_done,
    input logic       ev_frame_rx,
    input logic [7:0] flags_hi,
    input logic       mask_q,
    input logic [3:0] cu_cmd_code,
    input logic       cu_cmd_valid,
    input logic       cu_accept,
    input logic [2:0] ru_cmd_code,
    input logic       ru_cmd_valid,
    input logic       ru_accept,
    input logic       irq
);
    logic cmd_wr, ack_wr, ictl_wr;
    always_comb begin
        cmd_wr  = host_wr && !host_word && host_be[2];
        ack_wr  = host_wr && !host_word && host_be[1];
        ictl_wr = host_wr && !host_word && host_be[3];
    end

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_frame_rx |=> flags_hi[6]);

    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && host_wdata[14] && !ev_frame_rx) |=> !flags_hi[6]);

    assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmd_done && ack_wr && host_wdata[15]) |=> flags_hi[7]);

    assert_cu_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cu_cmd_valid && !cu_accept && !cmd_wr) |=> $stable(cu_cmd_code));

    assert_cu_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cu_cmd_valid && cu_accept && !cmd_wr) |=> !cu_cmd_valid);

    assert_ru_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_cmd_valid && !ru_accept && !cmd_wr) |=> $stable(ru_cmd_code));

    assert_ru_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_cmd_valid && ru_accept && !cmd_wr) |=> !ru_cmd_valid);

    assert_mask_quiets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq);

    assert_unmasked_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame_rx && !mask_q && !ictl_wr) |=> irq);
endmodule

bind nic_cmd_status_regs nic_cmd_status_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_word    (host_word),
    .host_be      (host_be),
    .host_wdata   (host_wdata),
    .ev_cmd_done  (ev_cmd_done),
    .ev_frame_rx  (ev_frame_rx),
    .flags_hi     (flags_hi),
    .mask_q       (mask_q),
    .cu_cmd_code  (cu_cmd_code),
    .cu_cmd_valid (cu_cmd_valid),
    .cu_accept    (cu_accept),
    .ru_cmd_code  (ru_cmd_code),
    .ru_cmd_valid (ru_cmd_valid),
    .ru_accept    (ru_accept),
    .irq          (irq)
);

// File: tb/nic_cmd_status_regs_test.sv
// Bench: directed corner cases, then seeded random traffic checked against
// a reference model built from the requirements.
module nic_cmd_status_regs_test;
    localparam int CLK_NS = 10;
    localparam int RAND_CYCLES = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_word = 1'b0;
    logic [3:0]  host_be = 4'h0;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] host_rdata;
    logic        ev_cmd_done = 0, ev_frame_rx = 0, ev_cu_idle = 0;
    logic        ev_rx_stall = 0, ev_mgmt_done = 0, ev_pause = 0;
    logic [1:0]  cu_state = 2'd0;
    logic [3:0]  ru_state = 4'd0;
    logic [3:0]  cu_cmd_code;
    logic        cu_cmd_valid, cu_accept = 1'b0;
    logic [2:0]  ru_cmd_code;
    logic        ru_cmd_valid, ru_accept = 1'b0;
    logic [31:0] ptr_out;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model state
    logic [7:0]  m_flags = 0;
    logic        m_mask = 0;
    logic [3:0]  m_cu = 0;
    logic [2:0]  m_ru = 0;
    logic [31:0] m_ptr = 0;

    always #(CLK_NS/2) clk = ~clk;

    nic_cmd_status_regs uut (.*);

    function automatic logic [31:0] exp_word0();
        return {7'b0, m_mask, m_cu, 1'b0, m_ru, m_flags, cu_state, ru_state, 2'b00};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic check_all(input string req);
        check({req, " rdata"}, host_rdata, host_word ? m_ptr : exp_word0());
        check({req, " cu_code"}, {28'b0, cu_cmd_code}, {28'b0, m_cu});
        check({req, " ru_code"}, {29'b0, ru_cmd_code}, {29'b0, m_ru});
        check({req, " valids"}, {30'b0, cu_cmd_valid, ru_cmd_valid}, {30'b0, m_cu != 0, m_ru != 0});
        check({req, " ptr_out"}, ptr_out, m_ptr);
        check({req, " irq"}, {31'b0, irq}, {31'b0, !m_mask && (m_flags != 0)});
    endtask

    // Advance model and design one clock; sample at the following negedge
    task automatic cycle();
        logic [7:0] set_v, clr_v, nf;
        logic [3:0] ncu; logic [2:0] nru; logic nm; logic [31:0] np;
        bit wc = host_wr && !host_word;
        set_v = {ev_cmd_done, ev_frame_rx, ev_cu_idle, ev_rx_stall, ev_mgmt_done,
                 wc && host_be[3] && host_wdata[25], 1'b0, ev_pause};
        clr_v = (wc && host_be[1]) ? (host_wdata[15:8] & 8'hFD) : 8'h00;
        nf = (m_flags & ~clr_v) | set_v;
        ncu = m_cu; nru = m_ru;
        if (wc && host_be[2] && host_wdata[23:20] != 0) ncu = host_wdata[23:20];
        else if (cu_accept) ncu = 0;
        if (wc && host_be[2] && host_wdata[18:16] != 0) nru = host_wdata[18:16];
        else if (ru_accept) nru = 0;
        nm = (wc && host_be[3]) ? host_wdata[24] : m_mask;
        np = m_ptr;
        for (int b = 0; b < 4; b++)
            if (host_wr && host_word && host_be[b]) np[b*8 +: 8] = host_wdata[b*8 +: 8];
        @(posedge clk);
        m_flags = nf; m_cu = ncu; m_ru = nru; m_mask = nm; m_ptr = np;
        @(negedge clk);
    endtask

    task automatic idle();
        host_wr = 0; host_be = 0; host_wdata = 0;
        {ev_cmd_done, ev_frame_rx, ev_cu_idle, ev_rx_stall, ev_mgmt_done, ev_pause} = '0;
        cu_accept = 0; ru_accept = 0; host_word = 0;
    endtask

    task automatic wr0(input logic [3:0] be, input logic [31:0] d);
        host_wr = 1; host_word = 0; host_be = be; host_wdata = d;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check("R1 word0", host_rdata, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 cmd", {cu_cmd_valid, ru_cmd_valid, 30'b0}, 32'h0);
        check("R1 ptr", ptr_out, 32'h0);

        // R9: live state fields
        cu_state = 2'b10; ru_state = 4'd12;
        #1 check("R9 state", host_rdata & 32'hFF, 32'h00B0);

        // R2: frame event sets bit 14 and raises irq (R8)
        ev_frame_rx = 1; cycle(); idle();
        check("R2 frame flag", host_rdata & 32'hFF00, 32'h4000);
        check("R8 irq unmasked", {31'b0, irq}, 32'h1);

        // R4: command-done event with same-cycle clear of bit 15; clear bit 14 too (R3)
        ev_cmd_done = 1; wr0(4'b0010, 32'h0000_C000); cycle(); idle();
        check("R4 event wins", host_rdata & 32'hFF00, 32'h8000);
        check("R3 w1c clears", host_rdata & 32'h4000, 32'h0);

        // R3: writing zeros leaves flags
        wr0(4'b0010, 32'h0); cycle(); idle();
        check("R3 zero write", host_rdata & 32'hFF00, 32'h8000);
        wr0(4'b0010, 32'h0000_8000); cycle(); idle();
        check("R3 clear last", {31'b0, irq}, 32'h0);

        // R5: both codes in one write
        wr0(4'b0100, 32'h0012_0000); cycle(); idle();
        check("R5 readback", host_rdata & 32'h00FF_0000, 32'h0012_0000);
        // R6: accept receive side only
        ru_accept = 1; cycle(); idle();
        check("R6 ru cleared", {29'b0, ru_cmd_code}, 32'h0);
        check("R6 cu kept", {28'b0, cu_cmd_code}, 32'h1);
        // R5: receive-only write leaves pending command code
        wr0(4'b0100, 32'h0004_0000); cycle(); idle();
        check("R5 zero field", host_rdata & 32'h00FF_0000, 32'h0014_0000);
        cu_accept = 1; ru_accept = 1; cycle(); idle();
        check("R6 both cleared", host_rdata & 32'h00FF_0000, 32'h0);
        cu_accept = 1; cycle(); idle();
        check("R6 spurious accept", {31'b0, cu_cmd_valid}, 32'h0);

        // R7: software interrupt with mask set
        wr0(4'b1000, 32'h0300_0000); cycle(); idle();
        check("R7 swi flag and mask", host_rdata & 32'hFF00_FF00, 32'h0100_0400);
        check("R8 masked irq", {31'b0, irq}, 32'h0);
        wr0(4'b1000, 32'h0); cycle(); idle();
        check("R8 unmask irq", {31'b0, irq}, 32'h1);
        wr0(4'b0010, 32'h0000_0400); cycle(); idle();
        check("R7 swi acked", host_rdata & 32'hFF00, 32'h0);

        // R10: partial pointer write
        host_wr = 1; host_word = 1; host_be = 4'b0101; host_wdata = 32'hA1B2_C3D4; cycle(); idle();
        host_word = 1; #1;
        check("R10 ptr bytes", host_rdata, 32'h00B2_00D4);
        check("R10 ptr_out", ptr_out, 32'h00B2_00D4);

        // Re-synchronise the model to the directed results
        m_flags = 0; m_mask = 0; m_cu = 0; m_ru = 0; m_ptr = 32'h00B2_00D4;
        check_all("R1 sync");

        // Random traffic across R2..R10
        for (int n = 0; n < RAND_CYCLES; n++) begin
            host_wr    = ($urandom % 3) == 0;
            host_word  = ($urandom % 4) == 0;
            host_be    = 4'($urandom);
            host_wdata = $urandom;
            ev_cmd_done  = ($urandom % 8) == 0;
            ev_frame_rx  = ($urandom % 8) == 0;
            ev_cu_idle   = ($urandom % 8) == 0;
            ev_rx_stall  = ($urandom % 8) == 0;
            ev_mgmt_done = ($urandom % 8) == 0;
            ev_pause     = ($urandom % 8) == 0;
            cu_accept    = ($urandom % 4) == 0;
            ru_accept    = ($urandom % 4) == 0;
            cu_state     = 2'($urandom);
            ru_state     = 4'($urandom);
            cycle();
            check_all("R2-R10 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule